// File: doc/BRIEF.md
# Command-Sequenced SPI Master

This block is a memory-mapped SPI master for serial flash and similar command-driven devices. Software sets a command byte, a send count, a receive count and a device select. It then loads the bytes to be sent into a small byte-addressed buffer and sets a start bit. The engine runs one half-duplex frame and holds the select low for the whole of it. The frame is the command byte, then the send bytes taken from the buffer, then the requested number of receive bytes.

Received bytes go back into the same buffer, directly behind the bytes that were sent. Software reads them there once the busy flag drops. One buffer pointer walks through the send bytes and then the receive bytes. A control bit rewinds that pointer to zero. If software does not rewind it, the next frame carries on from where the last one stopped.

The serial clock is the system clock divided by four, in SPI mode 0. While a frame runs, the host interface accepts no writes.

Top module: `spi_cmd_master`

## Requirements
- R1: After reset all four select outputs are high, `spi_sclk` and `spi_mosi` are low, and the control word at offset 0x00 reads 0.
- R2: The following registers read back what was written, with unused bits reading 0. The command byte is bits [7:0] of offset 0x00. The select field is bits [1:0] of offset 0x1D. The send count is at 0x48 and the receive count at 0x4B, each 8 bits in bits [7:0]. Buffer byte i is at offset 0x80+i, in bits [7:0].
- R3: A write to offset 0x00 with bit 16 set starts a frame. From the next cycle until the frame ends, bits 31 and 16 of offset 0x00 both read 1. They read 0 once the frame is over.
- R4: A frame shifts out bytes MSB first in this order: the command byte, then the send-count bytes from the buffer starting at the pointer, then receive-count bytes of 0x00. The select stays low for the whole frame.
- R5: Each byte sampled on `spi_miso` during the receive part is stored in the buffer at index pointer + send count + k, where k is the byte's position in the receive part.
- R6: A send or receive count of zero skips that part. With both counts at zero the frame is the command byte alone.
- R7: A control write with bit 20 set rewinds the buffer pointer to 0 before any frame started by the same write. Without it, a frame starts at the index where the previous frame stopped (previous start + send count + receive count).
- R8: Writes to any register or buffer byte while a frame is running have no effect.
- R9: `spi_sclk` idles low and is high for exactly 2 of every 4 system clocks. Rising edges are 4 clocks apart. `spi_mosi` changes only while `spi_sclk` is low.
- R10: During a frame only `spi_cs_n[v]` is low, where v is the select field value. All select outputs are high between frames.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 8 | Byte offset for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| spi_sclk | output | 1 | Serial clock, mode 0 |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 4 | Active-low device selects |

## Verification
The bench runs several corner cases against a scoreboard of the expected serial bytes, whose comparator plays the flash device:
- A frame with no send bytes checks that the receive part follows the command at once. A design that pulled a byte from the buffer there would put a stray byte on the wire.
- A command-only frame checks that the frame stops after 8 clocks. A design that treated a zero count as 256 would hang busy or overrun the scoreboard.
- A frame started without the rewind bit checks that send and receive data land after the previous frame's bytes. A design that rewound the pointer at every start would overwrite index 0.
- Writes made in mid-frame to a count, a buffer byte and the control word must leave all three unchanged. A design that let them through would read back the new values or start a second frame.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

  // register offsets (byte addressed, 8-bit offset space)
  localparam logic [7:0] OFS_CTRL = 8'h00;
  localparam logic [7:0] OFS_CSEL = 8'h1D;
  localparam logic [7:0] OFS_TXN  = 8'h48;
  localparam logic [7:0] OFS_RXN  = 8'h4B;
  localparam logic [7:0] OFS_BUF  = 8'h80;

  // control word bit positions
  localparam int GO_BIT   = 16;
  localparam int RWND_BIT = 20;
  localparam int BUSY_BIT = 31;

  typedef enum logic [1:0] {ST_IDLE, ST_SHIFT, ST_TRAIL} seq_st_t;
  typedef enum logic [1:0] {SEG_CMD, SEG_SEND, SEG_RECV} seg_t;

  // pack the readable control word
  function automatic logic [31:0] ctrl_word(input logic busy, input logic [7:0] cmd);
    logic [31:0] w;
    w = 32'h0;
    w[7:0] = cmd;
    w[GO_BIT] = busy;
    w[BUSY_BIT] = busy;
    return w;
  endfunction

  // offset of an address inside the buffer window
  function automatic logic [7:0] buf_offset(input logic [7:0] addr);
    return addr - OFS_BUF;
  endfunction

  // true when the address falls inside a buffer of the given depth
  function automatic logic buf_hit(input logic [7:0] addr, input int depth);
    logic [7:0] off;
    off = buf_offset(addr);
    return (addr >= OFS_BUF) && (int'(off) < depth);
  endfunction

endpackage

// File: rtl/spi_cmd_regs.sv
module spi_cmd_regs
  import spi_cmd_pkg::*;
#(
  parameter int CS_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_wr,
  input  logic [7:0]      bus_addr,
  input  logic [31:0]     bus_wdata,
  input  logic            busy,
  output logic [7:0]      cmd_eff,
  output logic [CS_W-1:0] csel,
  output logic [7:0]      tx_cnt,
  output logic [7:0]      rx_cnt,
  output logic            go,
  output logic            rewind,
  output logic [31:0]     reg_rdata
);

  logic [7:0]      cmd_q;
  logic [CS_W-1:0] csel_q;
  logic [7:0]      txn_q;
  logic [7:0]      rxn_q;
  logic            wr_ok;
  logic            ctrl_wr;

  assign wr_ok   = bus_wr && !busy;
  assign ctrl_wr = wr_ok && (bus_addr == OFS_CTRL);
  assign go      = ctrl_wr && bus_wdata[GO_BIT];
  assign rewind  = ctrl_wr && bus_wdata[RWND_BIT];
  // a start in the same write uses the freshly written command
  assign cmd_eff = ctrl_wr ? bus_wdata[7:0] : cmd_q;
  assign csel    = csel_q;
  assign tx_cnt  = txn_q;
  assign rx_cnt  = rxn_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      csel_q <= '0;
      txn_q  <= '0;
      rxn_q  <= '0;
    end else if (wr_ok) begin
      case (bus_addr)
        OFS_CTRL: cmd_q  <= bus_wdata[7:0];
        OFS_CSEL: csel_q <= bus_wdata[CS_W-1:0];
        OFS_TXN:  txn_q  <= bus_wdata[7:0];
        OFS_RXN:  rxn_q  <= bus_wdata[7:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (bus_addr)
      OFS_CTRL: reg_rdata = ctrl_word(busy, cmd_q);
      OFS_CSEL: reg_rdata[CS_W-1:0] = csel_q;
      OFS_TXN:  reg_rdata[7:0] = txn_q;
      OFS_RXN:  reg_rdata[7:0] = rxn_q;
      default:  reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/spi_cmd_buf.sv
module spi_cmd_buf #(
  parameter int DEPTH = 64,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_we,
  input  logic [IDX_W-1:0] host_idx,
  input  logic [7:0]       host_wdata,
  output logic [7:0]       host_rdata,
  input  logic             eng_we,
  input  logic [IDX_W-1:0] eng_idx,
  input  logic [7:0]       eng_wdata,
  output logic [7:0]       eng_rdata
);

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (eng_we) begin
      mem[eng_idx] <= eng_wdata;
    end else if (host_we) begin
      mem[host_idx] <= host_wdata;
    end
  end

  assign host_rdata = mem[host_idx];
  assign eng_rdata  = mem[eng_idx];

endmodule

// File: rtl/spi_cmd_seq.sv
module spi_cmd_seq
  import spi_cmd_pkg::*;
#(
  parameter int IDX_W  = 6,
  parameter int NUM_CS = 4,
  localparam int CS_W  = $clog2(NUM_CS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              rewind,
  input  logic [7:0]        cmd,
  input  logic [CS_W-1:0]   csel,
  input  logic [7:0]        tx_cnt,
  input  logic [7:0]        rx_cnt,
  output logic [IDX_W-1:0]  eng_idx,
  input  logic [7:0]        eng_rdata,
  output logic              eng_we,
  output logic [7:0]        eng_wdata,
  input  logic              miso,
  output logic              sclk,
  output logic              mosi,
  output logic [NUM_CS-1:0] cs_n,
  output logic              busy
);

  seq_st_t          st;
  seg_t             seg;
  logic [1:0]       ph;
  logic [2:0]       bitn;
  logic [7:0]       tx_sr;
  logic [7:0]       rx_sr;
  logic [7:0]       tx_left;
  logic [7:0]       rx_left;
  logic [IDX_W-1:0] ptr;
  logic [CS_W-1:0]  cs_q;

  // named internal events
  logic in_shift;
  logic byte_end;
  logic rx_sample;

  assign in_shift  = (st == ST_SHIFT);
  assign byte_end  = in_shift && (ph == 2'd3) && (bitn == 3'd7);
  assign rx_sample = in_shift && (seg == SEG_RECV) && (ph == 2'd2);

  assign busy      = (st != ST_IDLE);
  assign sclk      = in_shift && ph[1];
  assign mosi      = in_shift && tx_sr[7];
  assign eng_idx   = ptr;
  assign eng_we    = byte_end && (seg == SEG_RECV);
  assign eng_wdata = rx_sr;

  for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
    assign cs_n[g] = !(busy && (cs_q == CS_W'(g)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      seg     <= SEG_CMD;
      ph      <= '0;
      bitn    <= '0;
      tx_sr   <= '0;
      rx_sr   <= '0;
      tx_left <= '0;
      rx_left <= '0;
      ptr     <= '0;
      cs_q    <= '0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (rewind) ptr <= '0;
          if (go) begin
            st      <= ST_SHIFT;
            seg     <= SEG_CMD;
            ph      <= '0;
            bitn    <= '0;
            tx_sr   <= cmd;
            tx_left <= tx_cnt;
            rx_left <= rx_cnt;
            cs_q    <= csel;
          end
        end
        ST_SHIFT: begin
          ph <= ph + 2'd1;
          if (rx_sample) rx_sr <= {rx_sr[6:0], miso};
          if (ph == 2'd3) begin
            if (bitn != 3'd7) begin
              bitn  <= bitn + 3'd1;
              tx_sr <= {tx_sr[6:0], 1'b0};
            end else begin
              bitn <= '0;
              if (seg == SEG_RECV) ptr <= ptr + 1'b1;
              if (seg != SEG_RECV && tx_left != 8'd0) begin
                seg     <= SEG_SEND;
                tx_sr   <= eng_rdata;
                ptr     <= ptr + 1'b1;
                tx_left <= tx_left - 8'd1;
              end else if (rx_left != 8'd0) begin
                seg     <= SEG_RECV;
                tx_sr   <= '0;
                rx_left <= rx_left - 8'd1;
              end else begin
                st    <= ST_TRAIL;
                tx_sr <= '0;
              end
            end
          end
        end
        ST_TRAIL: begin
          ph <= ph + 2'd1;
          if (ph == 2'd3) st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/spi_cmd_master.sv
module spi_cmd_master
  import spi_cmd_pkg::*;
#(
  parameter int BUF_DEPTH = 64,
  parameter int NUM_CS    = 4,
  localparam int IDX_W    = $clog2(BUF_DEPTH),
  localparam int CS_W     = $clog2(NUM_CS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [7:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              spi_sclk,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic [NUM_CS-1:0] spi_cs_n
);

  logic             busy_w;
  logic [7:0]       cmd_w;
  logic [CS_W-1:0]  csel_w;
  logic [7:0]       tx_cnt_w;
  logic [7:0]       rx_cnt_w;
  logic             go_w;
  logic             rewind_w;
  logic [31:0]      reg_rdata;
  logic             in_buf;
  logic [7:0]       buf_ofs;
  logic             host_we;
  logic [7:0]       host_rdata;
  logic             eng_we;
  logic [IDX_W-1:0] eng_idx;
  logic [7:0]       eng_wdata;
  logic [7:0]       eng_rdata;

  assign in_buf  = buf_hit(bus_addr, BUF_DEPTH);
  assign buf_ofs = buf_offset(bus_addr);
  assign host_we = bus_wr && in_buf && !busy_w;

  spi_cmd_regs #(.CS_W(CS_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .busy     (busy_w),
    .cmd_eff  (cmd_w),
    .csel     (csel_w),
    .tx_cnt   (tx_cnt_w),
    .rx_cnt   (rx_cnt_w),
    .go       (go_w),
    .rewind   (rewind_w),
    .reg_rdata(reg_rdata)
  );

  spi_cmd_buf #(.DEPTH(BUF_DEPTH)) u_buf (
    .clk       (clk),
    .rst_n     (rst_n),
    .host_we   (host_we),
    .host_idx  (buf_ofs[IDX_W-1:0]),
    .host_wdata(bus_wdata[7:0]),
    .host_rdata(host_rdata),
    .eng_we    (eng_we),
    .eng_idx   (eng_idx),
    .eng_wdata (eng_wdata),
    .eng_rdata (eng_rdata)
  );

  spi_cmd_seq #(.IDX_W(IDX_W), .NUM_CS(NUM_CS)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (go_w),
    .rewind   (rewind_w),
    .cmd      (cmd_w),
    .csel     (csel_w),
    .tx_cnt   (tx_cnt_w),
    .rx_cnt   (rx_cnt_w),
    .eng_idx  (eng_idx),
    .eng_rdata(eng_rdata),
    .eng_we   (eng_we),
    .eng_wdata(eng_wdata),
    .miso     (spi_miso),
    .sclk     (spi_sclk),
    .mosi     (spi_mosi),
    .cs_n     (spi_cs_n),
    .busy     (busy_w)
  );

  assign bus_rdata = in_buf ? {24'h0, host_rdata} : reg_rdata;

endmodule

// File: rtl/spi_cmd_master_chk.sv
module spi_cmd_master_chk #(
  parameter int NUM_CS = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              go,
  input logic              sclk,
  input logic              mosi,
  input logic [NUM_CS-1:0] cs_n,
  input logic              host_we,
  input logic              eng_we,
  input logic [7:0]        tx_cnt
);

  // R10
  idle_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (&cs_n) && !sclk);

  // R10
  one_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> $countones(~cs_n) == 1);

  // R3
  go_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> busy);

  // R9
  sclk_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |=> sclk ##1 !sclk);

  // R9
  mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> $stable(mosi));

  // R8
  cnt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(tx_cnt));

  // R8
  port_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_we && eng_we));

endmodule

bind spi_cmd_master spi_cmd_master_chk #(.NUM_CS(NUM_CS)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .busy   (busy_w),
  .go     (go_w),
  .sclk   (spi_sclk),
  .mosi   (spi_mosi),
  .cs_n   (spi_cs_n),
  .host_we(host_we),
  .eng_we (eng_we),
  .tx_cnt (tx_cnt_w)
);

// File: tb/spi_cmd_master_bench.sv
module spi_cmd_master_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = 8'h0;
  logic [31:0] bus_wdata = 32'h0;
  logic [31:0] bus_rdata;
  logic        spi_sclk;
  logic        spi_mosi;
  logic        spi_miso = 1'b0;
  logic [3:0]  spi_cs_n;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit finished = 0;

  // scoreboard state
  logic [7:0] exp_q[$];
  logic [7:0] dev_bytes [16];
  int         exp_cs = 0;
  int         mptr = 0;

  always #5 clk = ~clk;

  spi_cmd_master u_spi_cmd_master (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_sclk(spi_sclk),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs_n(spi_cs_n)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  function automatic logic [7:0] dev_byte(input logic [7:0] seed, input int k);
    return seed ^ (8'(k) * 8'h35 + 8'h5A);
  endfunction

  // device model + monitor, sampled mid-cycle
  bit p_act = 0, p_sclk = 0;
  int sl_k = 0, sl_b = 0, mon_bits = 0, last_rise = -1;
  logic [7:0] mon_sr = 0;
  always @(negedge clk) begin
    bit act;
    cyc++;
    act = (spi_cs_n != 4'hF);
    if (act && !p_act) begin
      sl_k = 0; sl_b = 0; mon_bits = 0; last_rise = -1;
      spi_miso = dev_bytes[0][7];
      // R10: only the programmed select is low
      check(spi_cs_n == ~(4'b1 << exp_cs), "R10", {28'h0, spi_cs_n}, {28'h0, ~(4'b1 << exp_cs)});
    end
    if (act && spi_sclk && !p_sclk) begin
      if (last_rise >= 0)  // R9 rising edges 4 clocks apart
        check(cyc - last_rise == 4, "R9", cyc - last_rise, 4);
      last_rise = cyc;
      mon_sr = {mon_sr[6:0], spi_mosi};
      mon_bits++;
      if (mon_bits % 8 == 0) begin
        if (exp_q.size() == 0) check(0, "R4 extra byte", {24'h0, mon_sr}, 0);
        else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          check(mon_sr == e, "R4", {24'h0, mon_sr}, {24'h0, e});
        end
      end
    end
    if (act && !spi_sclk && p_sclk) begin
      sl_b++;
      if (sl_b == 8) begin sl_b = 0; sl_k++; end
      spi_miso = dev_bytes[sl_k % 16][7 - sl_b];
    end
    if (!act && p_act) begin
      // R6: frame length matches the expected byte count
      check(exp_q.size() == 0 && mon_bits % 8 == 0, "R6", mon_bits, 0);
    end
    p_act = act; p_sclk = spi_sclk;
  end

  // driver: program a frame, push expectations, run, read back received bytes
  task automatic run_frame(input int cs, input logic [7:0] cmd, input logic [7:0] txb [4],
                           input int ntx, input int nrx, input bit rwnd, input logic [7:0] seed,
                           input bit poke_busy);
    logic [31:0] d;
    if (rwnd) mptr = 0;
    exp_cs = cs;
    wr(8'h1D, cs);
    wr(8'h48, ntx);
    wr(8'h4B, nrx);
    for (int i = 0; i < ntx; i++) wr(8'h80 + 8'(mptr + i), {24'h0, txb[i]});
    for (int k = 0; k < 16; k++) dev_bytes[k] = dev_byte(seed, k);
    exp_q.push_back(cmd);
    for (int i = 0; i < ntx; i++) exp_q.push_back(txb[i]);
    for (int i = 0; i < nrx; i++) exp_q.push_back(8'h00);
    wr(8'h00, {11'h0, rwnd, 3'h0, 1'b1, 8'h0, cmd});
    rd(8'h00, d);
    // R3: busy and start bits read 1 during the frame
    check(d[31] && d[16], "R3 busy", d, 32'h8001_0000 | cmd);
    if (poke_busy) begin
      wr(8'h48, 32'h77);
      wr(8'h8A, 32'hEE);
      wr(8'h00, 32'h0001_00FF);
    end
    for (int n = 0; n < 2000; n++) begin
      rd(8'h00, d);
      if (!d[31]) break;
    end
    // R3: flag clears at the end
    check(d[31] == 0 && d[16] == 0, "R3 idle", d, {24'h0, cmd});
    for (int i = 0; i < nrx; i++) begin
      logic [7:0] e;
      e = dev_bytes[1 + ntx + i];
      rd(8'h80 + 8'(mptr + ntx + i), d);
      // R5: received byte stored after the sent bytes
      check(d[7:0] == e, "R5", d, {24'h0, e});
    end
    mptr = mptr + ntx + nrx;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [7:0] tb [4];
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check(spi_cs_n == 4'hF, "R1 cs", {28'h0, spi_cs_n}, 32'hF);
    check(spi_sclk == 0 && spi_mosi == 0, "R1 pins", {spi_sclk, spi_mosi}, 0);
    rd(8'h00, d);
    check(d == 0, "R1 ctrl", d, 0);

    // R2 register readback
    wr(8'h1D, 32'hFFFF_FFFE); rd(8'h1D, d); check(d == 32'h2, "R2 csel", d, 32'h2);
    wr(8'h48, 32'h1234_56A7); rd(8'h48, d); check(d == 32'hA7, "R2 txn", d, 32'hA7);
    wr(8'h4B, 32'h0000_0019); rd(8'h4B, d); check(d == 32'h19, "R2 rxn", d, 32'h19);
    wr(8'h00, 32'h0000_003C); rd(8'h00, d); check(d == 32'h3C, "R2 ctrl", d, 32'h3C);
    wr(8'h93, 32'h0000_00B6); rd(8'h93, d); check(d == 32'hB6, "R2 buf", d, 32'hB6);

    // preload for R8 check
    wr(8'h8A, 32'h11);

    // frame A: no send bytes (R6 skip), three receive bytes
    tb = '{8'h0, 8'h0, 8'h0, 8'h0};
    run_frame(1, 8'h9F, tb, 0, 3, 1, 8'h21, 0);

    // frame B: three send, two receive, with writes while busy (R8)
    tb = '{8'hA5, 8'h3C, 8'h81, 8'h0};
    run_frame(2, 8'h02, tb, 3, 2, 1, 8'h4E, 1);
    rd(8'h48, d); check(d == 32'h3, "R8 txn", d, 32'h3);
    rd(8'h8A, d); check(d == 32'h11, "R8 buf", d, 32'h11);
    rd(8'h00, d); check(d == 32'h02, "R8 ctrl", d, 32'h02);
    rd(8'h80, d); check(d == 32'hA5, "R5 tx kept", d, 32'hA5);

    // frame D: no rewind, pointer continues at 5 (R7)
    tb = '{8'h5E, 8'h0, 8'h0, 8'h0};
    run_frame(0, 8'h0B, tb, 1, 1, 0, 8'h97, 0);
    rd(8'h80, d); check(d == 32'hA5, "R7 index0 untouched", d, 32'hA5);
    rd(8'h85, d); check(d == 32'h5E, "R7 tx at 5", d, 32'h5E);

    // frame C: command only (R6), rewind
    run_frame(3, 8'hC7, tb, 0, 0, 1, 8'h00, 0);
    check(spi_cs_n == 4'hF, "R10 idle", {28'h0, spi_cs_n}, 32'hF);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule